// File: doc/BRIEF.md
# PCM Time-Slot Assignment Unit

This block places one 8-bit PCM channel into a programmable time slot of a serial TDM frame. Transmit and receive are handled independently. Each direction has its own frame-sync pulse, which marks the start of slot 0 in that direction. Each direction also has a bit and slot counter that restarts on that pulse. While the counter sits in the programmed slot, the transmit side drives the channel byte MSB first onto one of two lanes. In the same way, the receive side shifts in a byte from one of two lanes and presents it with a one-cycle strobe.

Assignments arrive as two-byte instructions over a chip-selected control port. That port is modelled as a chip-select line plus a byte strobe. The first byte picks the direction. The second byte carries an enable bit, a lane-select bit and the slot number. A written assignment waits in a shadow register and becomes active only at the start of the second frame of its own direction after chip-select is released. The whole block runs on the bit clock `clk`.

Top module: `pcm_slot_assigner`

## Requirements
- R1: After reset, both directions are disabled with slot 0 and lane 0. `tx_oe` is 0, `tx_ready` is 1 and `rx_valid` is 0, and a frame run in that state drives no lane and produces no receive strobe.
- R2: A frame-sync pulse sampled high on one clock makes the next clock bit period 0 of slot 0 in that direction. Slot n covers bit periods 8n to 8n+7 after the pulse, and a frame holds up to 64 slots.
- R3: An instruction consists of exactly two `ctl_stb` pulses while `ctl_cs_n` is low, followed by `ctl_cs_n` going high. First byte bit 0 selects the direction (0 transmit, 1 receive). Second byte bit 7 is the enable, bit 6 is the lane select, and bits 5:0 are the slot. A chip-select period with any other number of strobes changes nothing.
- R4: A new assignment takes effect at the second frame-sync of its direction after the chip-select release. The first frame after the release still uses the old assignment. A new instruction written before activation restarts the two-frame wait.
- R5: In the active slot of an enabled transmit assignment, `tx_oe` has only the selected lane's bit set, for exactly 8 cycles. `tx_dat` on that lane carries the buffered byte MSB first, and the other lane stays 0.
- R6: With transmit disabled, `tx_oe` stays 0, meaning both lanes are high impedance, for the whole frame, and `tx_dat` stays 0.
- R7: In the active slot of an enabled receive assignment, one bit per cycle is taken from the selected lane, MSB first. The other lane is ignored. `rx_valid` pulses for one cycle, with the byte on `rx_byte`, on the cycle after the last bit period.
- R8: With receive disabled, no `rx_valid` pulse occurs.
- R9: `tx_ready` is high when the transmit buffer is empty and the transmit side is not in its active slot. A `tx_load` accepted while `tx_ready` is high fills the buffer. A `tx_load` while `tx_ready` is low is ignored. The buffer empties at the end of the active slot, and if no new byte is loaded the last byte is sent again.
- R10: Each direction's two-frame wait counts only that direction's frame-sync pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_cs_n | input | 1 | Control chip-select, active low; its release ends an instruction |
| ctl_stb | input | 1 | One-cycle strobe marking a control byte |
| ctl_byte | input | 8 | Control byte taken with `ctl_stb` |
| tx_fs | input | 1 | Transmit frame-sync pulse |
| rx_fs | input | 1 | Receive frame-sync pulse |
| tx_data | input | BYTE_W | Byte offered to the transmit buffer |
| tx_load | input | 1 | Load strobe for `tx_data` |
| tx_ready | output | 1 | Transmit buffer can accept a byte |
| tx_dat | output | 2 | Transmit lane data (lane 0, lane 1) |
| tx_oe | output | 2 | Transmit lane drive enables; 0 means high impedance |
| rx_dat | input | 2 | Receive lane data (lane 0, lane 1) |
| rx_byte | output | BYTE_W | Last captured receive byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is new |

## Verification
The bench starts with activation timing, because that is where such a unit most often goes wrong. A design that switches too early would already drive the new slot in the first frame after the write. One that fails to restart the wait on a rewrite would jump to the earlier pending slot. One that counts the other direction's frame pulses would activate a transmit assignment after receive-only frames. Truncated and over-long instructions are sent to catch decoders that commit on any chip-select release. The bench also drives slot 63 in a 64-slot frame, where a counter that wraps or stops early loses the last byte. Receive lanes carry different data, so a swapped lane select or a misaligned capture shows up in `rx_byte`. A second load offered while the buffer is full must not overwrite the byte already waiting.

// File: rtl/pcm_slot_assigner.sv
module pcm_slot_assigner #(
  parameter int SLOT_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_cs_n,
  input  logic              ctl_stb,
  input  logic [7:0]        ctl_byte,
  input  logic              tx_fs,
  input  logic              rx_fs,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              tx_ready,
  output logic [1:0]        tx_dat,
  output logic [1:0]        tx_oe,
  input  logic [1:0]        rx_dat,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int POS_W = SLOT_W + BIT_W;
  localparam logic [POS_W-1:0] POS_LAST = '1;
  localparam logic [BIT_W-1:0] BIT_LAST = '1;

  typedef struct packed {
    logic              en;
    logic              lane;
    logic [SLOT_W-1:0] slot;
  } cfg_t;

  logic       cs_q;
  logic [1:0] nbyte;
  logic       dir_q;
  logic [7:0] arg_q;
  logic       commit;

  cfg_t             shadow   [2];
  cfg_t             active   [2];
  logic [1:0]       pend     [2];
  logic             in_frame [2];
  logic [POS_W-1:0] pos      [2];
  logic [1:0]       hit, last;
  logic [1:0]       fs_v;

  logic              tx_full;
  logic [BYTE_W-1:0] tx_buf;
  logic              tx_bit;
  logic [BYTE_W-1:0] rx_sh;
  logic              rx_in;

  assign fs_v   = {rx_fs, tx_fs};
  assign commit = ctl_cs_n && !cs_q && (nbyte == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      nbyte <= '0;
      dir_q <= 1'b0;
      arg_q <= '0;
    end else begin
      cs_q <= ctl_cs_n;
      if (ctl_cs_n) nbyte <= '0;
      else if (ctl_stb && nbyte != 2'd3) begin
        nbyte <= nbyte + 2'd1;
        if (nbyte == 2'd0) dir_q <= ctl_byte[0];
        if (nbyte == 2'd1) arg_q <= ctl_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++) begin
        shadow[d]   <= '0;
        active[d]   <= '0;
        pend[d]     <= '0;
        in_frame[d] <= 1'b0;
        pos[d]      <= '0;
      end
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (commit && dir_q == 1'(d)) begin
          shadow[d] <= '{en: arg_q[7], lane: arg_q[6], slot: arg_q[SLOT_W-1:0]};
          pend[d]   <= 2'd2;
        end else if (fs_v[d] && pend[d] != 2'd0) begin
          pend[d] <= pend[d] - 2'd1;
          if (pend[d] == 2'd1) active[d] <= shadow[d];
        end
        if (fs_v[d]) begin
          pos[d]      <= '0;
          in_frame[d] <= 1'b1;
        end else if (in_frame[d]) begin
          if (pos[d] == POS_LAST) in_frame[d] <= 1'b0;
          else pos[d] <= pos[d] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int d = 0; d < 2; d++) begin
      hit[d]  = in_frame[d] && active[d].en && (pos[d][POS_W-1:BIT_W] == active[d].slot);
      last[d] = hit[d] && (pos[d][BIT_W-1:0] == BIT_LAST);
    end
  end

  assign tx_ready = !tx_full && !hit[0];
  assign tx_bit   = tx_buf[~pos[0][BIT_W-1:0]];
  assign tx_oe    = hit[0] ? (active[0].lane ? 2'b10 : 2'b01) : 2'b00;
  assign tx_dat   = tx_oe & {2{tx_bit}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_buf  <= '0;
    end else if (tx_load && tx_ready) begin
      tx_full <= 1'b1;
      tx_buf  <= tx_data;
    end else if (last[0]) begin
      tx_full <= 1'b0;
    end
  end

  assign rx_in = rx_dat[active[1].lane];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (hit[1]) rx_sh <= {rx_sh[BYTE_W-2:0], rx_in};
      if (last[1]) begin
        rx_byte  <= {rx_sh[BYTE_W-2:0], rx_in};
        rx_valid <= 1'b1;
      end
    end
  end

  a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tx_oe));
  a_r9_not_ready_in_slot: assert property (@(posedge clk) disable iff (!rst_n) (tx_oe != 2'b00) |-> !tx_ready);
  a_r4_tx_holds_between_fs: assert property (@(posedge clk) disable iff (!rst_n) !tx_fs |=> $stable(active[0]));
  a_r4_rx_holds_between_fs: assert property (@(posedge clk) disable iff (!rst_n) !rx_fs |=> $stable(active[1]));
  a_r4_wait_bound: assert property (@(posedge clk) disable iff (!rst_n) (pend[0] <= 2'd2) && (pend[1] <= 2'd2));
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid);
endmodule

// File: tb/tb_pcm_slot_assigner.sv
`timescale 1ns/1ps
module tb_pcm_slot_assigner;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_cs_n = 1'b1, ctl_stb = 1'b0;
  logic [7:0] ctl_byte = '0;
  logic tx_fs = 1'b0, rx_fs = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_load = 1'b0;
  logic tx_ready;
  logic [1:0] tx_dat, tx_oe;
  logic [1:0] rx_dat = '0;
  logic [7:0] rx_byte;
  logic rx_valid;

  int errs = 0, checks = 0;
  int tx_cnt, tx_first, tx_lane, tx_bad, rx_cnt;
  logic [7:0] tx_val, rx_val;

  always #2.5 clk = ~clk;

  pcm_slot_assigner dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] lane_byte(input int lane, input int s);
    return lane ? {2'b10, 6'(s)} : {2'b01, 6'(s)};
  endfunction

  task automatic write_instr(input bit dir, input logic [7:0] b2, input int n);
    @(negedge clk);
    ctl_cs_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      ctl_stb = 1'b1;
      ctl_byte = (k == 0) ? {7'b0, dir} : b2;
      @(negedge clk);
    end
    ctl_stb = 1'b0;
    @(negedge clk);
    ctl_cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_tx(input logic [7:0] b);
    while (!tx_ready) @(negedge clk);
    tx_data = b;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic run_frame(input bit ftx, input bit frx, input int nslots);
    @(negedge clk);
    tx_fs = ftx;
    rx_fs = frx;
    @(negedge clk);
    tx_fs = 1'b0;
    rx_fs = 1'b0;
    tx_cnt = 0; tx_first = -1; tx_lane = 0; tx_bad = 0; rx_cnt = 0; tx_val = '0; rx_val = '0;
    for (int i = 0; i < nslots * 8; i++) begin
      if (rx_valid) begin rx_cnt++; rx_val = rx_byte; end
      if (tx_oe != 2'b00) begin
        if (tx_first < 0) tx_first = i;
        tx_cnt++;
        tx_lane = tx_oe[1] ? 1 : 0;
        if (tx_oe == 2'b11 || tx_dat[1-tx_lane]) tx_bad++;
        tx_val = {tx_val[6:0], tx_dat[tx_lane]};
      end else if (tx_dat != 2'b00) tx_bad++;
      rx_dat[0] = lane_byte(0, i / 8)[7 - (i % 8)];
      rx_dat[1] = lane_byte(1, i / 8)[7 - (i % 8)];
      @(negedge clk);
    end
    if (rx_valid) begin rx_cnt++; rx_val = rx_byte; end
    rx_dat = '0;
  endtask

  task automatic test_reset;
    chk(tx_oe == 2'b00, "R1 tx_oe", tx_oe, 0);
    chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    run_frame(1, 1, 16);
    chk(tx_cnt == 0, "R1 R6 no drive after reset", tx_cnt, 0);
    chk(rx_cnt == 0, "R1 R8 no strobe after reset", rx_cnt, 0);
  endtask

  task automatic test_tx_basic;
    load_tx(8'hA5);
    chk(tx_ready == 1'b0, "R9 full after load", tx_ready, 0);
    write_instr(0, 8'h83, 2);
    run_frame(1, 1, 16);
    chk(tx_cnt == 0, "R4 old assignment in first frame", tx_cnt, 0);
    run_frame(1, 1, 16);
    chk(tx_cnt == 8, "R5 eight drive cycles", tx_cnt, 8);
    chk(tx_first == 24, "R2 slot 3 start", tx_first, 24);
    chk(tx_lane == 0, "R5 lane 0", tx_lane, 0);
    chk(tx_val == 8'hA5, "R5 byte MSB first", tx_val, 8'hA5);
    chk(tx_bad == 0, "R5 idle lane quiet", tx_bad, 0);
    chk(tx_ready == 1'b1, "R9 empty after slot", tx_ready, 1);
  endtask

  task automatic test_tx_lane1;
    load_tx(8'h3C);
    write_instr(0, 8'hC9, 2);
    run_frame(1, 1, 16);
    chk(tx_first == 24 && tx_lane == 0, "R4 first frame keeps slot 3", tx_first, 24);
    chk(tx_val == 8'h3C, "R5 byte 3C", tx_val, 8'h3C);
    load_tx(8'h5A);
    run_frame(1, 1, 16);
    chk(tx_first == 72, "R2 slot 9 start", tx_first, 72);
    chk(tx_lane == 1, "R5 lane 1", tx_lane, 1);
    chk(tx_val == 8'h5A && tx_bad == 0, "R5 byte on lane 1", tx_val, 8'h5A);
  endtask

  task automatic test_incomplete;
    write_instr(0, 8'h82, 1);
    write_instr(0, 8'h82, 3);
    run_frame(1, 1, 16);
    run_frame(1, 1, 16);
    chk(tx_first == 72 && tx_lane == 1, "R3 bad byte count ignored", tx_first, 72);
  endtask

  task automatic test_rx;
    write_instr(1, 8'h85, 2);
    run_frame(1, 1, 16);
    chk(rx_cnt == 0, "R4 receive not yet active", rx_cnt, 0);
    run_frame(1, 1, 16);
    chk(rx_cnt == 1, "R7 single strobe", rx_cnt, 1);
    chk(rx_val == 8'h45, "R7 slot 5 lane 0 byte", rx_val, 8'h45);
    write_instr(1, 8'hCC, 2);
    run_frame(1, 1, 16);
    chk(rx_val == 8'h45, "R4 receive keeps old slot", rx_val, 8'h45);
    run_frame(1, 1, 16);
    chk(rx_val == 8'h8C && rx_cnt == 1, "R7 slot 12 lane 1 byte", rx_val, 8'h8C);
  endtask

  task automatic test_disable;
    write_instr(0, 8'h03, 2);
    write_instr(1, 8'h05, 2);
    run_frame(1, 1, 16);
    run_frame(1, 1, 16);
    chk(tx_cnt == 0 && tx_bad == 0, "R6 disabled transmit undriven", tx_cnt, 0);
    chk(rx_cnt == 0, "R8 disabled receive silent", rx_cnt, 0);
  endtask

  task automatic test_indep;
    write_instr(0, 8'h84, 2);
    load_tx(8'hE7);
    run_frame(0, 1, 16);
    run_frame(0, 1, 16);
    run_frame(1, 1, 16);
    chk(tx_cnt == 0, "R10 receive syncs not counted", tx_cnt, 0);
    run_frame(1, 1, 16);
    chk(tx_first == 32 && tx_val == 8'hE7, "R10 active after own syncs", tx_first, 32);
  endtask

  task automatic test_rewrite;
    load_tx(8'h61);
    write_instr(0, 8'h86, 2);
    run_frame(1, 1, 16);
    chk(tx_first == 32, "R4 slot 4 before rewrite", tx_first, 32);
    write_instr(0, 8'h87, 2);
    load_tx(8'h62);
    run_frame(1, 1, 16);
    chk(tx_first == 32, "R4 rewrite restarts wait", tx_first, 32);
    load_tx(8'h63);
    run_frame(1, 1, 16);
    chk(tx_first == 56 && tx_val == 8'h63, "R4 rewritten slot 7 active", tx_first, 56);
  endtask

  task automatic test_ignored_load;
    load_tx(8'h11);
    chk(tx_ready == 1'b0, "R9 not ready when full", tx_ready, 0);
    tx_data = 8'h22;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    run_frame(1, 1, 16);
    chk(tx_val == 8'h11, "R9 load while full ignored", tx_val, 8'h11);
    run_frame(1, 1, 16);
    chk(tx_val == 8'h11, "R9 byte repeated without load", tx_val, 8'h11);
  endtask

  task automatic test_slot63;
    write_instr(0, 8'hBF, 2);
    write_instr(1, 8'hFF, 2);
    run_frame(1, 1, 64);
    load_tx(8'h81);
    run_frame(1, 1, 64);
    chk(tx_first == 504 && tx_cnt == 8, "R2 slot 63 transmit", tx_first, 504);
    chk(tx_val == 8'h81, "R5 slot 63 byte", tx_val, 8'h81);
    chk(rx_cnt == 1 && rx_val == 8'hBF, "R7 slot 63 receive", rx_val, 8'hBF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset;
    test_tx_basic;
    test_tx_lane1;
    test_incomplete;
    test_rx;
    test_disable;
    test_indep;
    test_rewrite;
    test_ignored_load;
    test_slot63;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #750000;
    checks++;
    errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule